// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits in front of one flash segment and watches every write cycle presented to it. It looks for two command unlock sequences made of fixed address and data pairs. The three-write enable sequence turns software protection on and opens a load window. The six-write disable sequence turns protection off again. While protection is on, an ordinary data write is kept only if it falls inside the load window opened by the enable sequence. Outside that window the write is discarded and the protection state does not change. While protection is off, every write goes through.

A write is one clock cycle with the strobe high, carrying a segment-local address and a data byte. A separate pulse input marks the end of the load window. The block reports three things: whether the write in the current cycle is accepted, whether protection is on, and whether a non-command write would be blocked right now. Each segment keeps its own protection state, so a card with several segments uses one instance per segment. The block stores no array data.

Top module: `swp_seq_detect`

## Requirements
- R1: Out of reset, protection is off (`prot_on` = 0), `wr_block` = 0, and a write in the first cycle is accepted.
- R2: While protection is off, `wr_accept` equals `wr_stb` in the same cycle for every address and data value, including command bytes.
- R3: The writes AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, on three consecutive strobes, set `prot_on` to 1 on the clock edge of the third write and leave `wr_block` at 0, because the load window is open.
- R4: While the load window is open, every write is accepted. A `win_close` pulse on a clock edge closes the window, and `wr_block` reads 1 from the next cycle on. A write in the same cycle as the pulse is still accepted.
- R5: While protection is on and the window is closed, a write is not accepted and `prot_on` stays 1.
- R6: While protection is on and the window is closed, the command writes themselves are not accepted, even though they advance the matcher.
- R7: The writes AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 20h at 5555h clear `prot_on` on the edge of the sixth write. After that, writes are accepted again.
- R8: A write whose data does not match the expected step returns the matcher to idle. The same write is then checked as a first step, so AAh at 5555h twice in a row, followed by the rest of the enable sequence, still enables protection.
- R9: A write whose address is wrong but whose data is right also breaks the sequence. The sequence AAh at 5555h, 55h at 5555h, A0h at 5555h does not open a window.
- R10: A `win_close` pulse while no window is open has no effect on `prot_on` or `wr_block`.
- R11: Reset returns an instance that is protected to the unprotected state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One write cycle to the segment when high |
| wr_addr | input | ADDR_W | Segment-local write address |
| wr_data | input | DATA_W | Write data byte |
| win_close | input | 1 | Pulse that ends the load window |
| wr_accept | output | 1 | The write in this cycle is passed to the array |
| prot_on | output | 1 | Software protection is enabled |
| wr_block | output | 1 | A non-command write would be discarded now |

## Verification
The bench builds the block with its default parameters: a 15-bit address, an 8-bit data byte and command locations 5555h and 2AAAh. With these values, stimulus written with the real command addresses reaches every matcher step. A near-miss address that differs only in where it points (5555h used in place of 2AAAh) reaches the address compare without changing the data path. The vector walk and the directed tests drive both full sequences, a data mismatch and an address mismatch. They also cover window closing, including a close in the same cycle as a write, and a reset applied while protection is on.

// File: rtl/swp_seq_detect.sv
module swp_seq_detect #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_close,
  output logic              wr_accept,
  output logic              prot_on,
  output logic              wr_block
);

  localparam logic [DATA_W-1:0] C_LEAD  = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] C_SECND = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] C_ARM   = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] C_ESC   = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] C_OFF   = DATA_W'(8'h20);

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_D1, ST_D2, ST_D3, ST_OPEN
  } st_t;

  st_t st_q, st_d;
  logic prot_d;

  wire at_a = (wr_addr == CMD_ADDR_A);
  wire at_b = (wr_addr == CMD_ADDR_B);
  wire hit_lead  = wr_stb && at_a && (wr_data == C_LEAD);
  wire hit_secnd = wr_stb && at_b && (wr_data == C_SECND);
  wire hit_arm   = wr_stb && at_a && (wr_data == C_ARM);
  wire hit_esc   = wr_stb && at_a && (wr_data == C_ESC);
  wire hit_off   = wr_stb && at_a && (wr_data == C_OFF);
  wire restart   = hit_lead ? ST_P1 : ST_IDLE;

  assign wr_block  = prot_on && (st_q != ST_OPEN);
  assign wr_accept = wr_stb && !wr_block;

  always_comb begin
    st_d   = st_q;
    prot_d = prot_on;
    case (st_q)
      ST_IDLE: if (wr_stb) st_d = hit_lead ? ST_P1 : ST_IDLE;
      ST_P1:   if (wr_stb) st_d = hit_secnd ? ST_P2 : (hit_lead ? ST_P1 : ST_IDLE);
      ST_P2:   if (wr_stb) begin
        if (hit_arm) begin
          st_d   = ST_OPEN;
          prot_d = 1'b1;
        end else if (hit_esc) begin
          st_d = ST_D1;
        end else begin
          st_d = hit_lead ? ST_P1 : ST_IDLE;
        end
      end
      ST_D1:   if (wr_stb) st_d = hit_lead ? ST_D2 : ST_IDLE;
      ST_D2:   if (wr_stb) st_d = hit_secnd ? ST_D3 : (hit_lead ? ST_P1 : ST_IDLE);
      ST_D3:   if (wr_stb) begin
        if (hit_off) begin
          st_d   = ST_IDLE;
          prot_d = 1'b0;
        end else begin
          st_d = hit_lead ? ST_P1 : ST_IDLE;
        end
      end
      ST_OPEN: if (win_close) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      prot_on <= 1'b0;
    end else begin
      st_q    <= st_d;
      prot_on <= prot_d;
    end
  end

  // R3
  enable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_P2 && hit_arm) |=> (prot_on && !wr_block));

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_D3 && hit_off) |=> (!prot_on && wr_accept == wr_stb));

  // R5
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(prot_on));

  // R4
  close_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OPEN && win_close) |=> wr_block);

  // R2
  free_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_on && wr_stb) |-> wr_accept);

  // R10
  idle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && win_close && !wr_stb) |=> wr_block);

endmodule

// File: tb/swp_seq_detect_tb.sv
module swp_seq_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic win_close = 1'b0;
  logic wr_accept, prot_on, wr_block;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swp_seq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_close(win_close), .wr_accept(wr_accept),
    .prot_on(prot_on), .wr_block(wr_block)
  );

  // {req, stb, addr, data, close, exp_accept, exp_prot, exp_block}
  localparam int NV = 26;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 15'h1234, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    {4'd3,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    {4'd3,  1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd3,  1'b1, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd4,  1'b1, 15'h0010, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0}, // R4
    {4'd4,  1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd5,  1'b1, 15'h0011, 8'h44, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    {4'd6,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1}, // R6
    {4'd6,  1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd6,  1'b1, 15'h5555, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd6,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd6,  1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd7,  1'b1, 15'h5555, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1}, // R7
    {4'd7,  1'b1, 15'h0020, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0}, // R8
    {4'd8,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b1, 15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b1, 15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd8,  1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd8,  1'b0, 15'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd9,  1'b1, 15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b1}, // R9
    {4'd9,  1'b1, 15'h5555, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd9,  1'b1, 15'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd9,  1'b1, 15'h0030, 8'h99, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd10, 1'b0, 15'h0000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // R10
    {4'd10, 1'b1, 15'h0031, 8'h9A, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [14:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    wr_stb = s; wr_addr = a; wr_data = d; win_close = c;
    #1;
  endtask

  task automatic idle_cycle();
    step(1'b0, 15'h0, 8'h0, 1'b0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and first write
    step(1'b1, 15'h0100, 8'h11, 1'b0);
    chk(1, "prot_on after reset", prot_on, 1'b0);
    chk(1, "wr_block after reset", wr_block, 1'b0);
    chk(1, "first write accepted", wr_accept, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27], VEC[i][26:12], VEC[i][11:4], VEC[i][3]);
      chk(int'(VEC[i][31:28]), $sformatf("row %0d wr_accept", i), wr_accept, VEC[i][2]);
      chk(int'(VEC[i][31:28]), $sformatf("row %0d prot_on", i), prot_on, VEC[i][1]);
      chk(int'(VEC[i][31:28]), $sformatf("row %0d wr_block", i), wr_block, VEC[i][0]);
    end

    // R4 write in same cycle as window close: accepted, then blocked
    step(1'b1, 15'h5555, 8'hAA, 1'b0);
    step(1'b1, 15'h2AAA, 8'h55, 1'b0);
    step(1'b1, 15'h5555, 8'hA0, 1'b0);
    step(1'b1, 15'h0040, 8'hC3, 1'b1);
    chk(4, "write with close accepted", wr_accept, 1'b1);
    step(1'b1, 15'h0041, 8'hC4, 1'b0);
    chk(4, "write after close", wr_accept, 1'b0);
    chk(4, "block after close", wr_block, 1'b1);

    // R11 reset while protected
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(11, "prot_on in reset", prot_on, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 15'h0050, 8'hE1, 1'b0);
    chk(11, "write after reset", wr_accept, 1'b1);
    chk(11, "block after reset", wr_block, 1'b0);
    idle_cycle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule